// File: doc/BRIEF.md
# Fractional Time-of-Day Counter with Offset Slew

This block keeps a running time of day as a 48-bit count of seconds plus a 32-bit count of nanoseconds. Every clock cycle the time moves forward by a programmable step. The step has a 9-bit whole-nanosecond part and a 16-bit fractional part, and a 16-bit fraction accumulator turns the fractional part into whole nanoseconds over many cycles. Software can therefore trim the counter's rate to a small fraction of a nanosecond per cycle. When the nanosecond count reaches one billion, it wraps and the seconds count steps up in the same cycle.

A second programmable step, the slew step, can replace the normal step for a set number of cycles. Software writes the slew step and then writes a nonzero cycle count. The counter then runs fast or slow for exactly that many cycles and goes back to the normal step by itself. This shifts the time gradually instead of making it jump. Software can still load the time directly by writing the seconds and nanoseconds words.

All configuration and readback goes through a small word-addressed port with separate read and write strobes. Reads are combinational and return zero whenever the read strobe is low.

Top module: `todClock`

## Requirements
- R1: After reset the seconds and nanoseconds counts are zero. The normal step reads back as 8 whole ns and 0 fractional ns. The slew step and the slew cycle count read back as zero, and `adjActive` is low.
- R2: In each cycle without a time load, the nanoseconds count grows by the whole part of the active step. It grows by one more when adding the fractional part to the 16-bit fraction accumulator carries out of bit 15.
- R3: When the advanced nanosecond value is 1,000,000,000 or more, 1,000,000,000 is subtracted from it and the 48-bit seconds count rises by one in the same cycle. The rise carries from the low 32 bits into the high 16 bits.
- R4: A write to word 0 loads seconds bits 47:32 from data bits 15:0. A write to word 1 loads seconds bits 31:0. A write to word 2 loads the nanoseconds count. On any of these writes the cycle's advance is skipped and the fraction accumulator is cleared.
- R5: Writing a nonzero value to the count field of word 6 (bits 19:0) selects the slew step. The slew step is used for exactly that many cycles, starting in the next cycle. The count read from word 6 falls by one each cycle, and `adjActive` stays high while it is nonzero.
- R6: Writing zero to word 6 while a slew is running ends it. The normal step is used from the next cycle, and `adjActive` falls.
- R7: Word 3 and word 7 read as zero, and writes to them change nothing. Unused bits read as zero: bits 31:16 of word 0, bits 31:25 of words 4 and 5, and bits 31:20 of word 6. Data written into those bits is ignored.
- R8: Word 4 (normal step) and word 5 (slew step) both hold the fractional ns in bits 15:0 and the whole ns in bits 24:16.
- R9: `rdData` is zero whenever `rdEn` is low.
- R10: A write to word 4 or word 5 takes effect on the advance of the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational) |
| secondsOut | output | 48 | Current seconds count |
| nanosOut | output | 32 | Current nanoseconds count |
| adjActive | output | 1 | High while the slew step is in use |

## Verification
The bound properties check the following on every cycle:
- direct loads of the nanoseconds word and of the low seconds word;
- the seconds step when the nanosecond count is at or above one billion;
- the seconds count holding still while nanoseconds sit well below the limit;
- `adjActive` rising after a nonzero count write and falling after a zero count write;
- zero readback of the reserved word and of the unused seconds bits.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every cycle:
- the exact sequence of fraction carries at a non-integer step;
- the exact length of a slew and its decrementing readback;
- the one-cycle delay before a new step takes effect;
- a wrap out of a loaded out-of-range nanosecond value.

// File: rtl/todPkg.sv
package todPkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    W_SEC_HI     = 3'd0,
    W_SEC_LO     = 3'd1,
    W_NANOS      = 3'd2,
    W_RSVD       = 3'd3,
    W_PERIOD     = 3'd4,
    W_ADJ_PERIOD = 3'd5,
    W_ADJ_COUNT  = 3'd6
  } wordSel_e;

  typedef struct packed {
    logic loadSecHi;
    logic loadSecLo;
    logic loadNanos;
    logic useAdj;
  } ctrlStrobes_t;
endpackage

// File: rtl/todCtrl.sv
module todCtrl
  import todPkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 16,
  parameter int WNS_W      = 9,
  parameter int CNT_W      = 20,
  parameter int RESET_WHOLE = 8,
  parameter int RESET_FRAC  = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [FRAC_W+WNS_W-1:0] wrData,
  input  logic [SEC_W-1:0]     secIn,
  input  logic [NS_W-1:0]      nsIn,
  output ctrlStrobes_t         strobes,
  output logic [WNS_W-1:0]     perWhole,
  output logic [FRAC_W-1:0]    perFrac,
  output logic [WNS_W-1:0]     adjWhole,
  output logic [FRAC_W-1:0]    adjFrac,
  output logic                 adjActive,
  output logic [DATA_W-1:0]    rdData
);
  localparam int HI_W   = SEC_W - DATA_W;
  localparam int STEP_W = FRAC_W + WNS_W;

  logic [CNT_W-1:0] adjCnt;
  logic             wrPeriod, wrAdjPeriod, wrAdjCount;

  assign wrPeriod    = wrEn && (addr == W_PERIOD);
  assign wrAdjPeriod = wrEn && (addr == W_ADJ_PERIOD);
  assign wrAdjCount  = wrEn && (addr == W_ADJ_COUNT);

  always_comb begin
    strobes.loadSecHi = wrEn && (addr == W_SEC_HI);
    strobes.loadSecLo = wrEn && (addr == W_SEC_LO);
    strobes.loadNanos = wrEn && (addr == W_NANOS);
    strobes.useAdj    = (adjCnt != '0);
  end

  assign adjActive = (adjCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perWhole <= WNS_W'(RESET_WHOLE);
      perFrac  <= FRAC_W'(RESET_FRAC);
      adjWhole <= '0;
      adjFrac  <= '0;
    end else begin
      if (wrPeriod) begin
        perFrac  <= wrData[FRAC_W-1:0];
        perWhole <= wrData[STEP_W-1:FRAC_W];
      end
      if (wrAdjPeriod) begin
        adjFrac  <= wrData[FRAC_W-1:0];
        adjWhole <= wrData[STEP_W-1:FRAC_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               adjCnt <= '0;
    else if (wrAdjCount)     adjCnt <= wrData[CNT_W-1:0];
    else if (adjCnt != '0)   adjCnt <= adjCnt - 1'b1;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        W_SEC_HI:     rdData = DATA_W'(secIn[SEC_W-1:DATA_W]);
        W_SEC_LO:     rdData = secIn[DATA_W-1:0];
        W_NANOS:      rdData = DATA_W'(nsIn);
        W_PERIOD:     rdData = DATA_W'({perWhole, perFrac});
        W_ADJ_PERIOD: rdData = DATA_W'({adjWhole, adjFrac});
        W_ADJ_COUNT:  rdData = DATA_W'(adjCnt);
        default:      rdData = '0;
      endcase
    end
  end

  generate
    if (HI_W <= 0) begin : g_badWidth
      initial $error("todCtrl: seconds width must exceed the data word");
    end
  endgenerate
endmodule

// File: rtl/todDatapath.sv
module todDatapath
  import todPkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 16,
  parameter int WNS_W      = 9,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [WNS_W-1:0]   perWhole,
  input  logic [FRAC_W-1:0]  perFrac,
  input  logic [WNS_W-1:0]   adjWhole,
  input  logic [FRAC_W-1:0]  adjFrac,
  output logic [SEC_W-1:0]   secOut,
  output logic [NS_W-1:0]    nsOut
);
  localparam int HI_W  = SEC_W - DATA_W;
  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] NS_LIMIT = SUM_W'(NS_PER_SEC);

  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic [WNS_W-1:0]  actWhole;
  logic [FRAC_W-1:0] actFrac;
  logic [SUM_W-1:0]  nsSum;
  logic [SUM_W-1:0]  nsWrapped;
  logic              wrapSec;
  logic              anyLoad;

  assign actWhole = strobes.useAdj ? adjWhole : perWhole;
  assign actFrac  = strobes.useAdj ? adjFrac  : perFrac;
  assign anyLoad  = strobes.loadSecHi | strobes.loadSecLo | strobes.loadNanos;

  always_comb begin
    fracSum   = {1'b0, fracAcc} + {1'b0, actFrac};
    nsSum     = {1'b0, nsOut} + SUM_W'(actWhole) + SUM_W'(fracSum[FRAC_W]);
    wrapSec   = (nsSum >= NS_LIMIT);
    nsWrapped = wrapSec ? (nsSum - NS_LIMIT) : nsSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fracAcc <= '0;
      nsOut   <= '0;
      secOut  <= '0;
    end else if (anyLoad) begin
      fracAcc <= '0;
      if (strobes.loadSecHi) secOut[SEC_W-1:DATA_W] <= wrData[HI_W-1:0];
      if (strobes.loadSecLo) secOut[DATA_W-1:0]     <= wrData;
      if (strobes.loadNanos) nsOut                  <= NS_W'(wrData);
    end else begin
      fracAcc <= fracSum[FRAC_W-1:0];
      nsOut   <= nsWrapped[NS_W-1:0];
      if (wrapSec) secOut <= secOut + 1'b1;
    end
  end
endmodule

// File: rtl/todClock.sv
module todClock
  import todPkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 32,
  parameter int FRAC_W      = 16,
  parameter int WNS_W       = 9,
  parameter int CNT_W       = 20,
  parameter int RESET_WHOLE = 8,
  parameter int RESET_FRAC  = 0,
  parameter int NS_PER_SEC  = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [SEC_W-1:0]  secondsOut,
  output logic [NS_W-1:0]   nanosOut,
  output logic              adjActive
);
  localparam int STEP_W = FRAC_W + WNS_W;

  ctrlStrobes_t      strobes;
  logic [WNS_W-1:0]  perWhole, adjWhole;
  logic [FRAC_W-1:0] perFrac, adjFrac;

  todCtrl #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .WNS_W(WNS_W),
    .CNT_W(CNT_W), .RESET_WHOLE(RESET_WHOLE), .RESET_FRAC(RESET_FRAC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData[STEP_W-1:0]), .secIn(secondsOut), .nsIn(nanosOut),
    .strobes(strobes), .perWhole(perWhole), .perFrac(perFrac),
    .adjWhole(adjWhole), .adjFrac(adjFrac), .adjActive(adjActive),
    .rdData(rdData)
  );

  todDatapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .WNS_W(WNS_W),
    .NS_PER_SEC(NS_PER_SEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .perWhole(perWhole), .perFrac(perFrac),
    .adjWhole(adjWhole), .adjFrac(adjFrac),
    .secOut(secondsOut), .nsOut(nanosOut)
  );
endmodule

// File: rtl/todClockChecker.sv
module todClockChecker #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [2:0]       addr,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic [SEC_W-1:0] secondsOut,
  input logic [NS_W-1:0]  nanosOut,
  input logic             adjActive
);
  localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(NS_PER_SEC);
  localparam logic [NS_W:0] NS_SAFE  = NS_LIMIT - (NS_W+1)'(1024);

  logic timeWrite;
  assign timeWrite = wrEn && (addr <= 3'd2);

  AST_NS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2) |=> (nanosOut == $past(wrData))); // R4
  AST_SECLO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1) |=> (secondsOut[31:0] == $past(wrData))); // R4
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!timeWrite && {1'b0, nanosOut} >= NS_LIMIT) |=> (secondsOut == $past(secondsOut) + 1'b1)); // R3
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!timeWrite && {1'b0, nanosOut} < NS_SAFE) |=> $stable(secondsOut)); // R2
  AST_ADJ_START: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd6 && wrData[19:0] != 20'd0) |=> adjActive); // R5
  AST_ADJ_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd6 && wrData[19:0] == 20'd0) |=> !adjActive); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == 3'd3 || addr == 3'd7)) |-> (rdData == 32'd0)); // R7
  AST_SECHI_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0) |-> (rdData[31:16] == 16'd0)); // R7
endmodule

bind todClock todClockChecker #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .secondsOut(secondsOut),
  .nanosOut(nanosOut), .adjActive(adjActive)
);

// File: tb/todClock_bench.sv
module todClock_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint BILLION = 64'd1000000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [47:0] secondsOut;
  logic [31:0] nanosOut;
  logic        adjActive;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  longint mSec = 0, mNs = 0, mFrac = 0;
  longint mPw = 8, mPf = 0, mAw = 0, mAf = 0, mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  todClock u_todClock (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .secondsOut(secondsOut),
    .nanosOut(nanosOut), .adjActive(adjActive)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mNs = 0; mFrac = 0; mPw = 8; mPf = 0; mAw = 0; mAf = 0; mCnt = 0;
    end else begin
      longint w, f;
      w = (mCnt != 0) ? mAw : mPw;
      f = (mCnt != 0) ? mAf : mPf;
      if (wrEn && addr <= 3'd2) begin
        if (addr == 3'd0) mSec = (mSec & 64'hFFFF_FFFF) | (longint'(wrData[15:0]) << 32);
        if (addr == 3'd1) mSec = (mSec & 64'hFFFF_0000_0000) | longint'(wrData);
        if (addr == 3'd2) mNs = longint'(wrData);
        mFrac = 0;
      end else begin
        mFrac = mFrac + f;
        mNs = mNs + w + ((mFrac >= 65536) ? 1 : 0);
        if (mFrac >= 65536) mFrac = mFrac - 65536;
        if (mNs >= BILLION) begin
          mNs = mNs - BILLION;
          mSec = (mSec + 1) & 64'hFFFF_FFFF_FFFF;
        end
      end
      if (mCnt != 0) mCnt = mCnt - 1;
      if (wrEn && addr == 3'd4) begin mPf = wrData[15:0]; mPw = wrData[24:16]; end
      if (wrEn && addr == 3'd5) begin mAf = wrData[15:0]; mAw = wrData[24:16]; end
      if (wrEn && addr == 3'd6) mCnt = wrData[19:0];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (nanosOut !== mNs[31:0]) begin
        fails++; $display("FAIL R2 nanos: actual %0d expected %0d", nanosOut, mNs);
      end
      if (secondsOut !== mSec[47:0]) begin
        fails++; $display("FAIL R3 seconds: actual %0d expected %0d", secondsOut, mSec);
      end
      if (adjActive !== (mCnt != 0)) begin
        fails++; $display("FAIL R5 adjActive: actual %0b expected %0b", adjActive, mCnt != 0);
      end
    end
  end

  function automatic logic [31:0] expRead(int a);
    case (a)
      0: return {16'd0, mSec[47:32]};
      1: return mSec[31:0];
      2: return mNs[31:0];
      4: return {7'd0, mPw[8:0], mPf[15:0]};
      5: return {7'd0, mAw[8:0], mAf[15:0]};
      6: return {12'd0, mCnt[19:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; addr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string tag);
    rdEn = 1'b1; addr = 3'(a);
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s read word %0d: actual %h expected %h", tag, a, rdData, exp);
    end
    rdEn = 1'b0;
  endtask

  task automatic finishRun;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and R8 layout of the step word
    rdChk(0, 32'd0, "R1");
    rdChk(2, 32'd0, "R1");
    rdChk(4, 32'h0008_0000, "R1");
    rdChk(5, 32'd0, "R1");
    rdChk(6, 32'd0, "R1");
    // R9 read strobe low gives zero
    addr = 3'd4; #1; checks++;
    if (rdData !== 32'd0) begin fails++; $display("FAIL R9: actual %h expected 0", rdData); end
    // R2 default step
    idle(20);
    rdChk(2, expRead(2), "R2");
    // R10, R8: 7.5 ns step, fraction carries every other cycle
    wr(4, 32'h0007_8000);
    rdChk(4, 32'h0007_8000, "R8");
    idle(21);
    rdChk(2, expRead(2), "R10");
    // R4 load seconds and nanoseconds, R3 wrap with carry into upper seconds
    wr(0, 32'hABCD_1234);
    rdChk(0, 32'h0000_1234, "R7");
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'd999_999_990);
    rdChk(2, 32'd999_999_990, "R4");
    idle(4);
    rdChk(0, 32'h0000_1235, "R3");
    rdChk(1, 32'd0, "R3");
    // R5 slew at 100.25 ns for 5 cycles
    wr(5, 32'h0064_4000);
    rdChk(5, 32'h0064_4000, "R8");
    wr(6, 32'hFFF0_0005);
    rdChk(6, 32'd5, "R5");
    idle(2);
    rdChk(6, 32'd3, "R5");
    idle(6);
    rdChk(6, 32'd0, "R5");
    // R6 cancel a long slew
    wr(6, 32'd1000);
    idle(3);
    wr(6, 32'd0);
    rdChk(6, 32'd0, "R6");
    idle(5);
    // R7 unused bits and reserved words
    wr(4, 32'hFFFF_FFFF);
    rdChk(4, 32'h01FF_FFFF, "R7");
    wr(4, 32'h0008_0000);
    wr(3, 32'hDEAD_BEEF);
    rdChk(3, 32'd0, "R7");
    wr(7, 32'h1234_5678);
    rdChk(7, 32'd0, "R7");
    rdChk(4, 32'h0008_0000, "R7");
    // R3 out-of-range load wraps once per cycle
    wr(2, 32'hFFFF_FFF0);
    idle(3);
    rdChk(2, expRead(2), "R3");
    wr(2, 32'd0);
    // R4 load clears the fraction: odd fractional step after a load
    wr(4, 32'h0003_C000);
    idle(3);
    wr(2, 32'd100);
    idle(6);
    rdChk(2, expRead(2), "R4");
    idle(4);
    finishRun();
  end
endmodule